// File: doc/BRIEF.md
# I2C Target Address Recognizer

This block handles the address phase of an I2C target. It samples the bus lines SCL and SDA on the system clock, finds START, repeated START and STOP conditions, and shifts in the address byte MSB first. In 10-bit mode it also shifts in a second byte. The received address is compared against a programmed own address. Any own-address bit whose mask bit is 1 is treated as don't-care. A fixed filter of reserved addresses always wins over the mask.

On a hit, the block pulls SDA low for the acknowledge clock. It then reports the result to the host logic as a one-cycle match pulse, a separate general-call pulse, and the direction bit. Data transfer after the address is handled elsewhere, so is clock stretching. After the address phase the block parks until the next START or STOP.

The control sequence has six states:

| State | Meaning | Leaves when | Goes to |
|---|---|---|---|
| `ST_IDLE` | Bus free | START seen | `ST_HDR` |
| `ST_HDR` | Shifting the first byte | Eighth falling SCL edge, address accepted | `ST_HDR_ACK` |
| | | Eighth falling SCL edge, address refused | `ST_PARK` |
| `ST_HDR_ACK` | Acknowledging the first byte | Ninth falling SCL edge, 10-bit write header | `ST_LOW` |
| | | Ninth falling SCL edge, otherwise | `ST_PARK` |
| `ST_LOW` | Shifting the low 10-bit address byte | Eighth falling SCL edge, byte matched | `ST_LOW_ACK` |
| | | Eighth falling SCL edge, no match | `ST_PARK` |
| `ST_LOW_ACK` | Acknowledging the low byte | Ninth falling SCL edge | `ST_PARK` |
| `ST_PARK` | Ignoring the bus | START or STOP | `ST_HDR` or `ST_IDLE` |

From every state, START forces `ST_HDR` and STOP forces `ST_IDLE`.

Top module: `i2c_addr_matcher`

## Requirements
- R1: After reset, `sda_oe_n` is 1 (SDA released), `addr_match`, `gc_match` and `rw_bit` are 0, and the block waits in idle.
- R2: SDA falling while SCL is high (START or repeated START) restarts address capture from bit 0 in any state, including in the middle of a byte. SDA rising while SCL is high (STOP) returns the block to idle. Both release SDA.
- R3: Bits are taken on rising SCL edges, MSB first. On an accepted byte, `sda_oe_n` goes to 0 after the eighth falling SCL edge and returns to 1 after the ninth falling edge. On a refused byte it stays 1 throughout.
- R4: In 7-bit mode (`ten_bit_mode`=0), the first byte is `addr[6:0]`, R/W, with R/W in bit 0. It matches when every bit of `addr[6:0]` equals `own_addr[6:0]` wherever `addr_mask[6:0]` is 0. A match is acknowledged, `addr_match` pulses for exactly one cycle, and `rw_bit` takes the received R/W bit.
- R5: While `exact_cmp`=1 the mask is ignored and every address bit must equal the own address.
- R6: Address 0000000 with R/W=0 is acknowledged only when `gc_enable`=1. It then pulses `gc_match` and never `addr_match`. With `gc_enable`=0 it is refused. The two pulses are never high together.
- R7: These addresses are refused whatever the mask or own address: 0000000 with R/W=1, 0000001, 0000010, 0000011, 00001xx and 11111xx.
- R8: In 7-bit mode a first byte whose address is 11110xx is refused.
- R9: In 10-bit mode a first byte 11110 A9 A8 0 is acknowledged when A9:A8 match `own_addr[9:8]` under `addr_mask[9:8]`; no pulse is given yet. The following byte is then compared with `own_addr[7:0]` under `addr_mask[7:0]`. Only if it also matches is it acknowledged and `addr_match` pulsed with `rw_bit`=0.
- R10: In 10-bit mode a first byte 11110 A9 A8 1 is acknowledged only if a complete 10-bit write match has occurred since the last STOP and A9:A8 match. It then pulses `addr_match` with `rw_bit`=1. Otherwise it is refused.
- R11: In 10-bit mode a first byte that is neither a 10-bit header nor an accepted general call is refused.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL line as seen on the bus |
| sda_i | input | 1 | SDA line as seen on the bus (wired-AND of all drivers) |
| ten_bit_mode | input | 1 | 1 selects 10-bit addressing |
| own_addr | input | 10 | Own address; bits 6:0 are used in 7-bit mode |
| addr_mask | input | 10 | 1 makes the matching own-address bit don't-care |
| exact_cmp | input | 1 | 1 disables masking (exact compare) |
| gc_enable | input | 1 | 1 permits acknowledging the general call |
| sda_oe_n | output | 1 | Active-low SDA pull-down enable (open drain) |
| addr_match | output | 1 | One-cycle pulse when the own address is acknowledged |
| gc_match | output | 1 | One-cycle pulse when the general call is acknowledged |
| rw_bit | output | 1 | Direction of the last accepted address, 1 = read |

## Verification
The match path is driven with the following patterns:

- Exact and masked 7-bit addresses in both directions, so a true hit can be told apart from a near miss one bit away.
- The same masked address with exact compare forced on.
- A fully masked own address swept across every reserved group. This separates the fixed filter from the mask, because the mask alone would accept everything.
- 10-bit sequences: a good header with a bad low byte, a bad header, a masked low byte, a read header with and without a preceding write, and a read header after a STOP. These separate the two-stage compare and the remembered write match.
- Restarts issued after a refused byte and in the middle of a byte. These show that capture begins again from bit 0.

// File: rtl/i2c_am_pkg.sv
package i2c_am_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HDR,
        ST_HDR_ACK,
        ST_LOW,
        ST_LOW_ACK,
        ST_PARK
    } am_state_t;

    typedef struct packed {
        logic ack;        // acknowledge this byte
        logic final_hit;  // address phase complete with a hit
        logic gcall;      // hit is the general call
        logic to_low;     // a low 10-bit byte follows
        logic set_hold;   // 10-bit write match completed
        logic rw;         // direction reported on a final hit
    } am_verdict_t;

    // Fixed filter for 7-bit address values that must never be acknowledged.
    function automatic logic addr_is_reserved(input logic [6:0] a,
                                              input logic       rw,
                                              input logic       ten);
        logic r;
        r = 1'b0;
        if (a == 7'd0 && rw)                     r = 1'b1; // start byte
        if (a[6:2] == 5'b00000 && a[1:0] != 2'b0) r = 1'b1; // 0000001..0000011
        if (a[6:2] == 5'b00001)                  r = 1'b1; // high-speed code
        if (a[6:2] == 5'b11111)                  r = 1'b1;
        if (a[6:2] == 5'b11110 && !ten)          r = 1'b1; // header outside 10-bit mode
        return r;
    endfunction

endpackage

// File: rtl/i2c_am_sync.sv
module i2c_am_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_raw,
    input  logic sda_raw,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    localparam int LAST = STAGES - 1;

    logic [LAST:0][1:0] chain_q;
    logic               scl_prev_q;
    logic               sda_prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q    <= '1;
            scl_prev_q <= 1'b1;
            sda_prev_q <= 1'b1;
        end else begin
            chain_q    <= {chain_q[LAST-1:0], {scl_raw, sda_raw}};
            scl_prev_q <= chain_q[LAST][1];
            sda_prev_q <= chain_q[LAST][0];
        end
    end

    assign scl_s     = chain_q[LAST][1];
    assign sda_s     = chain_q[LAST][0];
    assign scl_rise  = scl_s & ~scl_prev_q;
    assign scl_fall  = ~scl_s & scl_prev_q;
    assign start_det = scl_s & scl_prev_q & sda_prev_q & ~sda_s;
    assign stop_det  = scl_s & scl_prev_q & ~sda_prev_q & sda_s;

endmodule

// File: rtl/i2c_am_judge.sv
module i2c_am_judge
    import i2c_am_pkg::*;
#(
    parameter int AW = 10
) (
    input  logic [7:0]    rx_byte,
    input  logic          low_stage,
    input  logic          ten_bit,
    input  logic [AW-1:0] own_addr,
    input  logic [AW-1:0] addr_mask,
    input  logic          exact_cmp,
    input  logic          gc_enable,
    input  logic          hold10,
    output am_verdict_t   verdict
);
    localparam int A7 = 7;

    logic [AW-1:0] care;
    logic [A7-1:0] a7;
    logic          rw;
    logic          is_gc;
    logic          is_hdr;
    logic          seven_ok;
    logic          upper_ok;
    logic          lower_ok;

    always_comb begin
        care     = exact_cmp ? '1 : ~addr_mask;
        a7       = rx_byte[7:1];
        rw       = rx_byte[0];
        is_gc    = (a7 == '0) && !rw;
        is_hdr   = (a7[6:2] == 5'b11110);
        seven_ok = ((a7 ^ own_addr[A7-1:0]) & care[A7-1:0]) == '0;
        upper_ok = ((a7[1:0] ^ own_addr[AW-1:AW-2]) & care[AW-1:AW-2]) == '0;
        lower_ok = ((rx_byte ^ own_addr[7:0]) & care[7:0]) == '0;

        verdict = '0;
        if (low_stage) begin
            if (lower_ok) begin
                verdict.ack       = 1'b1;
                verdict.final_hit = 1'b1;
                verdict.set_hold  = 1'b1;
            end
        end else if (is_gc) begin
            if (gc_enable) begin
                verdict.ack       = 1'b1;
                verdict.final_hit = 1'b1;
                verdict.gcall     = 1'b1;
            end
        end else if (addr_is_reserved(a7, rw, ten_bit)) begin
            verdict = '0;
        end else if (ten_bit) begin
            if (is_hdr && upper_ok) begin
                if (!rw) begin
                    verdict.ack    = 1'b1;
                    verdict.to_low = 1'b1;
                end else if (hold10) begin
                    verdict.ack       = 1'b1;
                    verdict.final_hit = 1'b1;
                    verdict.rw        = 1'b1;
                end
            end
        end else if (seven_ok) begin
            verdict.ack       = 1'b1;
            verdict.final_hit = 1'b1;
            verdict.rw        = rw;
        end
    end

endmodule

// File: rtl/i2c_addr_matcher.sv
module i2c_addr_matcher
    import i2c_am_pkg::*;
#(
    parameter int AW        = 10,
    parameter int BITS      = 8,
    parameter int SYNC_STGS = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          scl_i,
    input  logic          sda_i,
    input  logic          ten_bit_mode,
    input  logic [AW-1:0] own_addr,
    input  logic [AW-1:0] addr_mask,
    input  logic          exact_cmp,
    input  logic          gc_enable,
    output logic          sda_oe_n,
    output logic          addr_match,
    output logic          gc_match,
    output logic          rw_bit
);
    localparam int CW = $clog2(BITS + 1);

    logic            scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    am_state_t       state_q, state_d;
    logic [CW-1:0]   bit_cnt_q;
    logic [BITS-1:0] shreg_q;
    logic            hold10_q;
    logic            cont_q;
    logic            shifting;
    logic            byte_done;
    logic            in_ack;
    am_verdict_t     verdict;

    i2c_am_sync #(.STAGES(SYNC_STGS)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_raw  (scl_i),
        .sda_raw  (sda_i),
        .scl_s    (scl_s),
        .sda_s    (sda_s),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_det(start_det),
        .stop_det (stop_det)
    );

    i2c_am_judge #(.AW(AW)) u_judge (
        .rx_byte  (shreg_q[7:0]),
        .low_stage(state_q == ST_LOW),
        .ten_bit  (ten_bit_mode),
        .own_addr (own_addr),
        .addr_mask(addr_mask),
        .exact_cmp(exact_cmp),
        .gc_enable(gc_enable),
        .hold10   (hold10_q),
        .verdict  (verdict)
    );

    assign shifting  = (state_q == ST_HDR) || (state_q == ST_LOW);
    assign in_ack    = (state_q == ST_HDR_ACK) || (state_q == ST_LOW_ACK);
    assign byte_done = shifting && scl_fall && (bit_cnt_q == CW'(BITS));

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (stop_det) begin
            state_d = ST_IDLE;
        end else if (start_det) begin
            state_d = ST_HDR;
        end else begin
            unique case (state_q)
                ST_IDLE:    state_d = ST_IDLE;
                ST_HDR:     if (byte_done) state_d = verdict.ack ? ST_HDR_ACK : ST_PARK;
                ST_HDR_ACK: if (scl_fall)  state_d = cont_q ? ST_LOW : ST_PARK;
                ST_LOW:     if (byte_done) state_d = verdict.ack ? ST_LOW_ACK : ST_PARK;
                ST_LOW_ACK: if (scl_fall)  state_d = ST_PARK;
                ST_PARK:    state_d = ST_PARK;
                default:    state_d = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // bit capture and 10-bit bookkeeping
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt_q <= '0;
            shreg_q   <= '0;
            hold10_q  <= 1'b0;
            cont_q    <= 1'b0;
        end else begin
            if (start_det || stop_det || in_ack) begin
                bit_cnt_q <= '0;
            end else if (shifting && scl_rise && bit_cnt_q != CW'(BITS)) begin
                bit_cnt_q <= bit_cnt_q + 1'b1;
                shreg_q   <= {shreg_q[BITS-2:0], sda_s};
            end
            if (stop_det)
                hold10_q <= 1'b0;
            else if (byte_done && verdict.set_hold)
                hold10_q <= 1'b1;
            if (byte_done && state_q == ST_HDR)
                cont_q <= verdict.to_low;
        end
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sda_oe_n   <= 1'b1;
            addr_match <= 1'b0;
            gc_match   <= 1'b0;
            rw_bit     <= 1'b0;
        end else begin
            addr_match <= 1'b0;
            gc_match   <= 1'b0;
            if (start_det || stop_det) begin
                sda_oe_n <= 1'b1;
            end else if (byte_done) begin
                sda_oe_n <= ~verdict.ack;
                if (verdict.ack && verdict.final_hit) begin
                    addr_match <= ~verdict.gcall;
                    gc_match   <= verdict.gcall;
                    rw_bit     <= verdict.rw;
                end
            end else if (in_ack && scl_fall) begin
                sda_oe_n <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/i2c_am_checker.sv
module i2c_am_checker
    import i2c_am_pkg::*;
(
    input logic      clk,
    input logic      rst_n,
    input am_state_t state,
    input logic      start_det,
    input logic      stop_det,
    input logic      scl_fall,
    input logic      sda_oe_n,
    input logic      addr_match,
    input logic      gc_match,
    input logic      gc_enable
);

    assert_stop_idles_R2: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (sda_oe_n && state == ST_IDLE));

    assert_start_rearms_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (start_det && !stop_det) |=> (sda_oe_n && state == ST_HDR));

    assert_drive_in_ack_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !sda_oe_n |-> (state == ST_HDR_ACK || state == ST_LOW_ACK));

    assert_low_ack_ends_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LOW_ACK && scl_fall && !start_det && !stop_det) |=> sda_oe_n);

    assert_match_single_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        addr_match |=> !addr_match);

    assert_match_drives_ack_R4: assert property (@(posedge clk) disable iff (!rst_n)
        addr_match |-> !sda_oe_n);

    assert_gc_needs_enable_R6: assert property (@(posedge clk) disable iff (!rst_n)
        gc_match |-> $past(gc_enable));

    assert_pulses_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(addr_match && gc_match));

endmodule

bind i2c_addr_matcher i2c_am_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .state     (state_q),
    .start_det (start_det),
    .stop_det  (stop_det),
    .scl_fall  (scl_fall),
    .sda_oe_n  (sda_oe_n),
    .addr_match(addr_match),
    .gc_match  (gc_match),
    .gc_enable (gc_enable)
);

// File: tb/i2c_addr_matcher_bench.sv
module i2c_addr_matcher_bench;
    localparam int CLK_PERIOD = 10;
    localparam int Q          = 10;   // system clocks per quarter SCL period

    typedef struct {
        string      tag;
        int         nm;
        int         ng;
        logic       rw;
        logic [7:0] acks;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl = 1'b1;
    logic       sda_m = 1'b1;
    logic       ten_bit_mode = 1'b0;
    logic [9:0] own_addr = '0;
    logic [9:0] addr_mask = '0;
    logic       exact_cmp = 1'b0;
    logic       gc_enable = 1'b0;
    logic       sda_oe_n, addr_match, gc_match, rw_bit;
    logic       bus;

    int         vectors = 0;
    int         fails = 0;
    bit         finished = 1'b0;
    exp_t       exp_q[$];
    logic [7:0] obs_acks = '0;

    assign bus = sda_m & sda_oe_n;

    always #(CLK_PERIOD / 2) clk = ~clk;

    i2c_addr_matcher u_i2c_addr_matcher (
        .clk         (clk),
        .rst_n       (rst_n),
        .scl_i       (scl),
        .sda_i       (bus),
        .ten_bit_mode(ten_bit_mode),
        .own_addr    (own_addr),
        .addr_mask   (addr_mask),
        .exact_cmp   (exact_cmp),
        .gc_enable   (gc_enable),
        .sda_oe_n    (sda_oe_n),
        .addr_match  (addr_match),
        .gc_match    (gc_match),
        .rw_bit      (rw_bit)
    );

    task automatic check_val(input string what, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    task automatic wq(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic cfg(input logic ten, input logic [9:0] own, input logic [9:0] msk,
                       input logic exact, input logic gce);
        ten_bit_mode = ten; own_addr = own; addr_mask = msk;
        exact_cmp = exact; gc_enable = gce;
        wq(2);
    endtask

    task automatic expect_txn(input string tag, input int nm, input int ng,
                              input logic rw, input logic [7:0] acks);
        exp_t e;
        e.tag = tag; e.nm = nm; e.ng = ng; e.rw = rw; e.acks = acks;
        obs_acks = '0;
        exp_q.push_back(e);
    endtask

    task automatic bus_start();
        wq(Q); sda_m = 1'b1; wq(Q); scl = 1'b1; wq(Q); sda_m = 1'b0; wq(Q); scl = 1'b0;
    endtask

    task automatic bus_stop();
        wq(Q); sda_m = 1'b0; wq(Q); scl = 1'b1; wq(Q); sda_m = 1'b1; wq(2 * Q);
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            wq(Q); sda_m = b[i]; wq(Q); scl = 1'b1; wq(2 * Q); scl = 1'b0;
        end
    endtask

    task automatic send_byte(input logic [7:0] b, input logic exp_ack, input string tag);
        for (int i = 7; i >= 0; i--) begin
            wq(Q); sda_m = b[i]; wq(Q); scl = 1'b1; wq(Q);
            if (i == 0) check_val({"R3 sda_oe_n before ack window ", tag}, sda_oe_n, 1);
            wq(Q); scl = 1'b0;
        end
        wq(Q); sda_m = 1'b1; wq(Q); scl = 1'b1; wq(Q);
        obs_acks = {obs_acks[6:0], ~bus};
        check_val({"R3 sda_oe_n in ninth clock ", tag}, sda_oe_n, int'(!exp_ack));
        wq(Q); scl = 1'b0;
        wq(6);
        check_val({"R3 sda_oe_n after ninth clock ", tag}, sda_oe_n, 1);
    endtask

    // monitor: gathers pulses per transaction and compares at STOP
    initial begin
        int   n_m;
        int   n_g;
        logic last_rw;
        logic p_scl;
        logic p_sda;
        exp_t e;
        n_m = 0; n_g = 0; last_rw = 1'b0; p_scl = 1'b1; p_sda = 1'b1;
        forever begin
            @(negedge clk);
            if (rst_n) begin
                if (addr_match) begin n_m++; last_rw = rw_bit; end
                if (gc_match) n_g++;
                if (scl && p_scl && bus && !p_sda) begin
                    if (exp_q.size() == 0) begin
                        check_val("R2 unexpected transaction", 1, 0);
                    end else begin
                        e = exp_q.pop_front();
                        check_val({e.tag, " ack pattern"}, int'(obs_acks), int'(e.acks));
                        check_val({e.tag, " addr_match pulses"}, n_m, e.nm);
                        check_val({e.tag, " gc_match pulses"}, n_g, e.ng);
                        if (e.nm > 0) check_val({e.tag, " rw_bit"}, last_rw, e.rw);
                    end
                    n_m = 0; n_g = 0;
                end
            end
            p_scl = scl; p_sda = bus;
        end
    end

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        vectors++; fails++;
        $display("FAIL watchdog R1-path run did not end actual=timeout expected=finish");
        finish_run();
    end

    initial begin
        wq(3);
        rst_n = 1'b1;
        wq(4);
        check_val("R1 sda_oe_n after reset", sda_oe_n, 1);
        check_val("R1 addr_match after reset", addr_match, 0);
        check_val("R1 gc_match after reset", gc_match, 0);
        check_val("R1 rw_bit after reset", rw_bit, 0);

        // 7-bit exact compare
        cfg(1'b0, 10'h050, 10'h000, 1'b0, 1'b0);
        expect_txn("R4 write hit", 1, 0, 1'b0, 8'b1);
        bus_start(); send_byte(8'hA0, 1'b1, "R4 write"); bus_stop();
        expect_txn("R4 read hit", 1, 0, 1'b1, 8'b1);
        bus_start(); send_byte(8'hA1, 1'b1, "R4 read"); bus_stop();
        expect_txn("R4 near miss", 0, 0, 1'b0, 8'b0);
        bus_start(); send_byte(8'hA2, 1'b0, "R4 miss"); bus_stop();

        // masked compare: own 0000000, mask 0010000
        cfg(1'b0, 10'h000, 10'h010, 1'b0, 1'b0);
        expect_txn("R4 masked write", 1, 0, 1'b0, 8'b1);
        bus_start(); send_byte(8'h20, 1'b1, "R4 masked"); bus_stop();
        expect_txn("R4 masked read", 1, 0, 1'b1, 8'b1);
        bus_start(); send_byte(8'h21, 1'b1, "R4 masked read"); bus_stop();
        cfg(1'b0, 10'h000, 10'h010, 1'b1, 1'b0);
        expect_txn("R5 exact ignores mask", 0, 0, 1'b0, 8'b0);
        bus_start(); send_byte(8'h20, 1'b0, "R5 exact"); bus_stop();

        // general call
        cfg(1'b0, 10'h000, 10'h000, 1'b0, 1'b0);
        expect_txn("R6 gc disabled", 0, 0, 1'b0, 8'b0);
        bus_start(); send_byte(8'h00, 1'b0, "R6 off"); bus_stop();
        cfg(1'b0, 10'h050, 10'h000, 1'b0, 1'b1);
        expect_txn("R6 gc enabled", 0, 1, 1'b0, 8'b1);
        bus_start(); send_byte(8'h00, 1'b1, "R6 on"); bus_stop();

        // reserved filter with a fully masked own address
        cfg(1'b0, 10'h050, 10'h07F, 1'b0, 1'b0);
        expect_txn("R7 start byte", 0, 0, 1'b0, 8'b0);
        bus_start(); send_byte(8'h01, 1'b0, "R7 start byte"); bus_stop();
        expect_txn("R7 0000001", 0, 0, 1'b0, 8'b0);
        bus_start(); send_byte(8'h02, 1'b0, "R7 0000001"); bus_stop();
        expect_txn("R7 0000011", 0, 0, 1'b0, 8'b0);
        bus_start(); send_byte(8'h06, 1'b0, "R7 0000011"); bus_stop();
        expect_txn("R7 00001xx", 0, 0, 1'b0, 8'b0);
        bus_start(); send_byte(8'h0A, 1'b0, "R7 00001xx"); bus_stop();
        expect_txn("R7 11111xx", 0, 0, 1'b0, 8'b0);
        bus_start(); send_byte(8'hF9, 1'b0, "R7 11111xx"); bus_stop();
        expect_txn("R8 header in 7-bit mode", 0, 0, 1'b0, 8'b0);
        bus_start(); send_byte(8'hF0, 1'b0, "R8 header"); bus_stop();
        expect_txn("R7 masked control hit", 1, 0, 1'b0, 8'b1);
        bus_start(); send_byte(8'h9E, 1'b1, "R7 control"); bus_stop();

        // restarts
        cfg(1'b0, 10'h050, 10'h000, 1'b0, 1'b0);
        expect_txn("R2 restart after refused byte", 1, 0, 1'b0, 8'b01);
        bus_start(); send_byte(8'hFF, 1'b0, "R2 refused");
        bus_start(); send_byte(8'hA0, 1'b1, "R2 after restart"); bus_stop();
        expect_txn("R2 restart mid-byte", 1, 0, 1'b1, 8'b1);
        bus_start(); send_bits(8'hE0, 3);
        bus_start(); send_byte(8'hA1, 1'b1, "R2 mid-byte"); bus_stop();

        // 10-bit addressing, own 10'h2C5
        cfg(1'b1, 10'h2C5, 10'h000, 1'b0, 1'b0);
        expect_txn("R9 10-bit write hit", 1, 0, 1'b0, 8'b11);
        bus_start(); send_byte(8'hF4, 1'b1, "R9 header"); send_byte(8'hC5, 1'b1, "R9 low"); bus_stop();
        expect_txn("R9 low byte miss", 0, 0, 1'b0, 8'b10);
        bus_start(); send_byte(8'hF4, 1'b1, "R9 header"); send_byte(8'hC4, 1'b0, "R9 low miss"); bus_stop();
        expect_txn("R9 header miss", 0, 0, 1'b0, 8'b0);
        bus_start(); send_byte(8'hF2, 1'b0, "R9 header miss"); bus_stop();
        expect_txn("R10 read without write", 0, 0, 1'b0, 8'b0);
        bus_start(); send_byte(8'hF5, 1'b0, "R10 cold read"); bus_stop();
        expect_txn("R11 7-bit byte in 10-bit mode", 0, 0, 1'b0, 8'b0);
        bus_start(); send_byte(8'hA0, 1'b0, "R11"); bus_stop();
        cfg(1'b1, 10'h2C5, 10'h001, 1'b0, 1'b0);
        expect_txn("R9 masked low byte", 1, 0, 1'b0, 8'b11);
        bus_start(); send_byte(8'hF4, 1'b1, "R9 header"); send_byte(8'hC4, 1'b1, "R9 masked low"); bus_stop();
        expect_txn("R10 read after write", 2, 0, 1'b1, 8'b111);
        bus_start(); send_byte(8'hF4, 1'b1, "R10 header"); send_byte(8'hC5, 1'b1, "R10 low");
        bus_start(); send_byte(8'hF5, 1'b1, "R10 read header"); bus_stop();
        expect_txn("R10 read after STOP", 0, 0, 1'b0, 8'b0);
        bus_start(); send_byte(8'hF5, 1'b0, "R10 stale read"); bus_stop();
        cfg(1'b1, 10'h2C5, 10'h000, 1'b0, 1'b1);
        expect_txn("R6 gc in 10-bit mode", 0, 1, 1'b0, 8'b1);
        bus_start(); send_byte(8'h00, 1'b1, "R6 gc 10-bit"); bus_stop();

        wq(Q);
        check_val("R2 all transactions seen", exp_q.size(), 0);
        finish_run();
    end

endmodule